// File: doc/BRIEF.md
# PLCP Transmit Frame Generator

This block builds the transmit convergence frame that carries ATM cells over a 1.544 Mbit/s line. A frame has ten rows. Each row opens with two fixed alignment octets, a row identifier octet and one path-overhead octet, and then carries a full 53-octet cell. A six-octet trailer closes the frame, so one frame is 576 octets long. The block only produces the octet stream. Line framing and bit insertion onto the line are handled downstream. The downstream consumer sets the frame rate, which is one frame every 3 ms, by how it pulls octets.

Cells enter one octet at a time on a valid/ready port. When no cell is offered, an idle cell is sent in its place. The overhead octet of each row has a fixed role, given in row order:
- Rows 0 to 3 are reserved and carry zero.
- Row 4 is the user channel.
- Row 5 is the parity octet.
- Row 6 is path status.
- Rows 7 and 8 are management.
- Row 9 is the pad counter.

The parity octet holds an even bit-interleaved parity over the previous frame. The user channel, status and management octets are taken from plain input pins at the moment they are emitted.

Back-pressure works as follows. The output presents an octet with `out_valid` and moves on only when `out_ready` is high. While `out_valid` is high and `out_ready` is low, the octet and the frame-start flag stay unchanged. On the input, the row's decision is taken when its overhead octet is accepted. If `in_valid` is high at that moment, the row carries the offered cell. The block then takes one input octet for each output octet it accepts in the cell field (`in_ready` follows `out_ready`). If the source drops `in_valid` in the middle of a cell, `out_valid` drops with it. An upstream source must hold `in_valid` and `in_data` steady until the octet is taken.

Top module: `plcp_tx_framer`

## Requirements
- R1: While `rst_n` is low, `out_valid` is low. The first octet offered after reset is the first alignment octet of a frame, with `out_sof` high.
- R2: A frame is 10 rows of 57 octets (alignment 2, identifier 1, overhead 1, cell 53) followed by 6 trailer octets, 576 octets in all. `out_sof` is high on the first octet of each frame and on no other octet.
- R3: Every row starts with the alignment octets 0xF6 and then 0x28.
- R4: The identifier octet of row n is taken from the parameter `POI_CODES`, with row 0 in the top byte. The default values for rows 0 to 9 are 0x2C, 0x29, 0x25, 0x20, 0x1C, 0x19, 0x15, 0x10, 0x0D and 0x08.
- R5: The overhead octets in rows 0 to 3 are 0x00. Row 4 carries `user_chan`, row 6 `path_status`, row 7 `mgmt_a`, row 8 `mgmt_b`, and row 9 the fixed `C1_CODE` (default 0x00).
- R6: The overhead octet of row 5 equals the XOR of every identifier, overhead and cell octet of the previous frame. It is 0x00 in the first frame after reset.
- R7: The six trailer octets are all `TRAILER_FILL` (default 0xCC).
- R8: If `in_valid` is high when a row's overhead octet is accepted, the row's 53 cell octets are the next 53 input octets, in order.
- R9: Otherwise the row carries the idle cell 0x00, 0x00, 0x00, 0x01, 0x52 followed by 48 octets of 0x6A. `in_ready` stays low for that row, so no input is consumed.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_sof` hold their values into the next cycle. This does not apply to the overhead octet, whose source pins may change.
- R11: In the cell field of a row that carries input, `out_valid` equals `in_valid`. `in_ready` is high exactly when `out_ready` is high in the cell field of such a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input cell octet offered |
| in_ready | output | 1 | Input cell octet taken this cycle |
| in_data | input | 8 | Input cell octet |
| out_valid | output | 1 | Output octet offered |
| out_ready | input | 1 | Consumer takes the output octet |
| out_data | output | 8 | Output frame octet |
| out_sof | output | 1 | First octet of a frame |
| user_chan | input | 8 | User channel overhead octet |
| path_status | input | 8 | Path status overhead octet |
| mgmt_a | input | 8 | First management overhead octet |
| mgmt_b | input | 8 | Second management overhead octet |

## Verification
The bench runs six consecutive frames and checks every octet against a position-based model. Frame 0 has no cells offered, which isolates the idle cell and the zero parity. Frames 1 and 2 are filled with numbered cells whose content varies with both cell number and octet index, so any slip or skipped octet shows up as a mismatch. Frame 3 runs out of cells halfway through, testing the live-to-idle switch within a frame, and frame 4 is idle again. The consumer throttles from frame 1 onward and the source stalls mid-cell, which exercises output hold and input stall separately. The overhead inputs change every frame, so the parity octet in each later frame depends on different data.

// File: rtl/plcp_pkg.sv
`timescale 1ns/1ps
package plcp_pkg;
  localparam int ROWS    = 10;
  localparam int HDR_OCT = 4;

  localparam logic [7:0] FRAME_A1  = 8'hF6;
  localparam logic [7:0] FRAME_A2  = 8'h28;
  localparam logic [7:0] IDLE_HEC  = 8'h52;
  localparam logic [7:0] IDLE_FILL = 8'h6A;

  typedef enum logic [2:0] {
    SEG_A1,
    SEG_A2,
    SEG_POI,
    SEG_POH,
    SEG_CELL,
    SEG_TRL
  } seg_e;
endpackage

// File: rtl/plcp_seq.sv
`timescale 1ns/1ps
module plcp_seq
  import plcp_pkg::*;
#(
  parameter int CELL_OCTETS    = 53,
  parameter int TRAILER_OCTETS = 6,
  localparam int COLS = HDR_OCT + CELL_OCTETS,
  localparam int RW   = $clog2(ROWS),
  localparam int CW   = $clog2(COLS),
  localparam int TW   = $clog2(TRAILER_OCTETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output seg_e          seg,
  output logic [RW-1:0] row,
  output logic [CW-1:0] cell_idx,
  output logic          frame_first,
  output logic          frame_cell_end
);
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic [TW-1:0] trl_q;
  logic          in_trl_q;

  wire col_last = (col_q == CW'(COLS - 1));
  wire row_last = (row_q == RW'(ROWS - 1));
  wire trl_last = (trl_q == TW'(TRAILER_OCTETS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q    <= '0;
      col_q    <= '0;
      trl_q    <= '0;
      in_trl_q <= 1'b0;
    end else if (adv) begin
      if (in_trl_q) begin
        if (trl_last) begin
          in_trl_q <= 1'b0;
          trl_q    <= '0;
          row_q    <= '0;
          col_q    <= '0;
        end else begin
          trl_q <= trl_q + 1'b1;
        end
      end else if (col_last) begin
        col_q <= '0;
        if (row_last) in_trl_q <= 1'b1;
        else          row_q    <= row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (in_trl_q)                 seg = SEG_TRL;
    else if (col_q == CW'(0))     seg = SEG_A1;
    else if (col_q == CW'(1))     seg = SEG_A2;
    else if (col_q == CW'(2))     seg = SEG_POI;
    else if (col_q == CW'(3))     seg = SEG_POH;
    else                          seg = SEG_CELL;
  end

  assign row            = row_q;
  assign cell_idx       = col_q - CW'(HDR_OCT);
  assign frame_first    = !in_trl_q && (row_q == '0) && (col_q == '0);
  assign frame_cell_end = !in_trl_q && row_last && col_last;
endmodule

// File: rtl/plcp_cell_src.sv
`timescale 1ns/1ps
module plcp_cell_src
  import plcp_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          poh_take,
  input  logic          is_cell,
  input  logic [CW-1:0] cell_idx,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          out_ready,
  output logic [7:0]    cell_data,
  output logic          cell_ok,
  output logic          in_ready
);
  logic       live_q;
  logic [7:0] idle_oct;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        live_q <= 1'b0;
    else if (poh_take) live_q <= in_valid;
  end

  always_comb begin
    if (cell_idx < CW'(3))       idle_oct = 8'h00;
    else if (cell_idx == CW'(3)) idle_oct = 8'h01;
    else if (cell_idx == CW'(4)) idle_oct = IDLE_HEC;
    else                         idle_oct = IDLE_FILL;
  end

  assign cell_data = live_q ? in_data : idle_oct;
  assign cell_ok   = live_q ? in_valid : 1'b1;
  assign in_ready  = is_cell && live_q && out_ready;

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cell && !live_q) |-> (!in_ready && cell_ok));
endmodule

// File: rtl/plcp_bip.sv
`timescale 1ns/1ps
module plcp_bip (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       close,
  input  logic [7:0] octet,
  output logic [7:0] b1
);
  logic [7:0] acc_q;
  logic [7:0] b1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      b1_q  <= '0;
    end else if (take) begin
      if (close) begin
        b1_q  <= acc_q ^ octet;
        acc_q <= '0;
      end else begin
        acc_q <= acc_q ^ octet;
      end
    end
  end

  assign b1 = b1_q;
endmodule

// File: rtl/plcp_tx_framer.sv
`timescale 1ns/1ps
module plcp_tx_framer
  import plcp_pkg::*;
#(
  parameter int          CELL_OCTETS    = 53,
  parameter int          TRAILER_OCTETS = 6,
  parameter logic [79:0] POI_CODES      = {8'h2C, 8'h29, 8'h25, 8'h20, 8'h1C,
                                           8'h19, 8'h15, 8'h10, 8'h0D, 8'h08},
  parameter logic [7:0]  C1_CODE        = 8'h00,
  parameter logic [7:0]  TRAILER_FILL   = 8'hCC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sof,
  input  logic [7:0] user_chan,
  input  logic [7:0] path_status,
  input  logic [7:0] mgmt_a,
  input  logic [7:0] mgmt_b
);
  localparam int COLS      = HDR_OCT + CELL_OCTETS;
  localparam int RW        = $clog2(ROWS);
  localparam int CW        = $clog2(COLS);
  localparam int FRAME_OCT = ROWS * COLS + TRAILER_OCTETS;
  localparam int FW        = $clog2(FRAME_OCT + 1);

  seg_e          seg;
  logic [RW-1:0] row_w;
  logic [CW-1:0] cell_idx;
  logic          frame_first, frame_cell_end;
  logic [7:0]    cell_data, b1_w, poh_oct;
  logic          cell_ok, adv;
  logic [7:0]    poi_tab [ROWS];

  for (genvar g = 0; g < ROWS; g++) begin : g_poi
    assign poi_tab[g] = POI_CODES[(ROWS - 1 - g) * 8 +: 8];
  end

  plcp_seq #(.CELL_OCTETS(CELL_OCTETS), .TRAILER_OCTETS(TRAILER_OCTETS)) seq_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .seg(seg), .row(row_w),
    .cell_idx(cell_idx), .frame_first(frame_first),
    .frame_cell_end(frame_cell_end)
  );

  plcp_cell_src #(.CW(CW)) src_i (
    .clk(clk), .rst_n(rst_n), .poh_take(adv && seg == SEG_POH),
    .is_cell(seg == SEG_CELL), .cell_idx(cell_idx), .in_valid(in_valid),
    .in_data(in_data), .out_ready(out_ready), .cell_data(cell_data),
    .cell_ok(cell_ok), .in_ready(in_ready)
  );

  plcp_bip bip_i (
    .clk(clk), .rst_n(rst_n),
    .take(adv && (seg == SEG_POI || seg == SEG_POH || seg == SEG_CELL)),
    .close(adv && frame_cell_end), .octet(out_data), .b1(b1_w)
  );

  always_comb begin
    case (int'(row_w))
      4:       poh_oct = user_chan;
      5:       poh_oct = b1_w;
      6:       poh_oct = path_status;
      7:       poh_oct = mgmt_a;
      8:       poh_oct = mgmt_b;
      9:       poh_oct = C1_CODE;
      default: poh_oct = 8'h00;
    endcase
  end

  always_comb begin
    case (seg)
      SEG_A1:   out_data = FRAME_A1;
      SEG_A2:   out_data = FRAME_A2;
      SEG_POI:  out_data = poi_tab[row_w];
      SEG_POH:  out_data = poh_oct;
      SEG_CELL: out_data = cell_data;
      default:  out_data = TRAILER_FILL;
    endcase
  end

  assign out_valid = rst_n && (seg != SEG_CELL || cell_ok);
  assign out_sof   = frame_first;
  assign adv       = out_valid && out_ready;

  // Checker state: octets accepted since the last frame start.
  logic [FW-1:0] oct_cnt;
  logic          seen_sof;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oct_cnt  <= '0;
      seen_sof <= 1'b0;
    end else if (adv) begin
      if (out_sof) begin
        oct_cnt  <= FW'(1);
        seen_sof <= 1'b1;
      end else begin
        oct_cnt <= oct_cnt + 1'b1;
      end
    end
  end

  // R1
  first_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !seen_sof) |-> out_sof);

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof && seen_sof) |-> (oct_cnt == FW'(FRAME_OCT)));

  // R3
  sof_a1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> (out_data == FRAME_A1));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && seg != SEG_POH) |=>
      (out_valid && $stable(out_data) && $stable(out_sof)));

  // R11
  take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |-> (out_valid && out_ready && out_data == in_data));
endmodule

// File: tb/plcp_tx_framer_tb_top.sv
`timescale 1ns/1ps
module plcp_tx_framer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_sof;
  logic [7:0] user_chan = 8'h00, path_status = 8'h00, mgmt_a = 8'h00, mgmt_b = 8'h00;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  plcp_tx_framer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .user_chan(user_chan),
    .path_status(path_status), .mgmt_a(mgmt_a), .mgmt_b(mgmt_b)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cell_oct(input int c, input int k);
    return 8'((c * 37 + k * 11 + 5) & 255);
  endfunction

  function automatic logic [7:0] poi_exp(input int r);
    case (r)
      0: return 8'h2C; 1: return 8'h29; 2: return 8'h25; 3: return 8'h20;
      4: return 8'h1C; 5: return 8'h19; 6: return 8'h15; 7: return 8'h10;
      8: return 8'h0D; default: return 8'h08;
    endcase
  endfunction

  function automatic logic [7:0] idle_exp(input int k);
    if (k < 3) return 8'h00;
    if (k == 3) return 8'h01;
    if (k == 4) return 8'h52;
    return 8'h6A;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5 * 100000);
    fails++;
    $display("FAIL watchdog: actual 0x%02h expected 0x%02h", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    int b_row = 0, b_col = 0, b_trl = 0, b_frame = 0;
    bit b_intrl = 0, b_live = 0, loaded = 0, keep = 0;
    bit prev_hold = 0;
    logic [7:0] prev_data = 8'h00;
    logic [7:0] acc = 8'h00, b1_exp = 8'h00;
    int exp_c = 0, src_c = 0, src_k = 0, src_left = 0;
    int cyc = 0;

    // R1: reset state
    repeat (3) begin
      @(negedge clk); #1;
      chk(out_valid == 1'b0, "R1 reset valid", {7'd0, out_valid}, 8'h00);
    end
    @(negedge clk); rst_n = 1'b1;

    while (b_frame < 6) begin
      bit stall, rdy, v, ev, er, esof, cellcol, fire, src_fire;
      logic [7:0] ed;
      string tag;
      if (cyc > 0) @(negedge clk);
      cyc++;
      if (b_frame == 1 && !loaded) begin src_left = 25; loaded = 1; end
      stall = (cyc % 9 == 4);
      rdy   = (b_frame == 0) ? 1'b1 : (cyc % 7 != 2);
      v     = (src_left > 0) && (keep || !stall);
      in_valid    = v;
      in_data     = cell_oct(src_c, src_k);
      out_ready   = rdy;
      user_chan   = 8'(8'h30 + b_frame);
      path_status = 8'(8'h50 + b_frame * 3);
      mgmt_a      = 8'(8'h90 ^ b_frame);
      mgmt_b      = 8'(8'hA0 + b_frame * 5);
      #1;

      cellcol = !b_intrl && b_col >= 4;
      ev   = !(cellcol && b_live && !v);
      er   = cellcol && b_live && rdy;
      esof = !b_intrl && b_row == 0 && b_col == 0;
      if (b_intrl) begin ed = 8'hCC; tag = "R7 trailer"; end
      else if (b_col == 0) begin ed = 8'hF6; tag = "R3 A1"; end
      else if (b_col == 1) begin ed = 8'h28; tag = "R3 A2"; end
      else if (b_col == 2) begin ed = poi_exp(b_row); tag = "R4 identifier"; end
      else if (b_col == 3) begin
        case (b_row)
          4: ed = user_chan;  5: ed = b1_exp;  6: ed = path_status;
          7: ed = mgmt_a;     8: ed = mgmt_b;  default: ed = 8'h00;
        endcase
        tag = (b_row == 5) ? "R6 parity" : "R5 overhead";
      end else if (b_live) begin ed = cell_oct(exp_c, b_col - 4); tag = "R8 live cell"; end
      else begin ed = idle_exp(b_col - 4); tag = "R9 idle cell"; end

      chk(out_valid == ev, "R11 out_valid", {7'd0, out_valid}, {7'd0, ev});
      chk(in_ready == er, "R11 in_ready", {7'd0, in_ready}, {7'd0, er});
      if (cellcol && !b_live)
        chk(in_ready == 1'b0, "R9 no take", {7'd0, in_ready}, 8'h00);
      if (ev) begin
        chk(out_data == ed, tag, out_data, ed);
        chk(out_sof == esof, "R2 sof", {7'd0, out_sof}, {7'd0, esof});
        if (cyc == 1)
          chk(out_sof == 1'b1, "R1 first octet", {7'd0, out_sof}, 8'h01);
      end
      if (prev_hold && !(b_col == 3 && !b_intrl))
        chk(out_data == prev_data, "R10 hold", out_data, prev_data);

      fire     = ev && rdy;
      src_fire = v && er;
      prev_hold = ev && !rdy;
      prev_data = out_data;
      if (fire) begin
        if (!b_intrl && b_col >= 2) acc ^= ed;
        if (!b_intrl && b_col == 3) b_live = v;
        if (cellcol && b_live && b_col == 56) exp_c++;
        if (!b_intrl && b_row == 9 && b_col == 56) begin b1_exp = acc; acc = 8'h00; end
        if (b_intrl) begin
          if (b_trl == 5) begin b_intrl = 0; b_trl = 0; b_row = 0; b_col = 0; b_frame++; end
          else b_trl++;
        end else if (b_col == 56) begin
          b_col = 0;
          if (b_row == 9) b_intrl = 1; else b_row++;
        end else b_col++;
      end
      if (src_fire) begin
        src_k++;
        if (src_k == 53) begin src_k = 0; src_c++; src_left--; end
      end
      keep = v && !src_fire;
    end
    // R8: all loaded cells must have passed through
    chk(exp_c == 25, "R8 cell count", 8'(exp_c), 8'd25);
    finish_run();
  end
endmodule